// File: doc/BRIEF.md
# Host–Coprocessor Mailbox Unit

This block passes short messages between a control processor (the host) and one SIMD coprocessor. It holds three one-way queues of 32-bit words. The command queue carries words from the host to the coprocessor. The response queue and the alert queue carry words from the coprocessor to the host. A word placed in the alert queue also raises an interrupt line to the host.

The coprocessor side uses channel ports that stall rather than fail. A read request waits until a command word is present. A write request waits until the chosen outbound queue has room. The host side is a simple register port with four word addresses:

| Address | Write | Read |
|---------|-------|------|
| 0 | post a command | returns zero |
| 1 | ignored | pop the response queue |
| 2 | ignored | pop the alert queue |
| 3 | control (bit 0 clears the interrupt) | status counts |

In the usual exchange, the host posts a command, and the coprocessor reads it and acts on it. The coprocessor then posts a response, and only after that reads the next command.

Top module: `mbox_unit`

## Requirements
- R1: After a synchronous active-low reset, all queues are empty, the status word reads 0x00000004, `host_irq` is 0, `cop_rd_ack` is 0 and `cop_wr_ack` is 1.
- R2: Command words written by the host at address 0 reach `cop_rd_data` in the order they were written. A word is consumed on each clock edge where `cop_rd_req` and `cop_rd_ack` are both 1.
- R3: While the command queue is empty, `cop_rd_ack` stays 0 and a held `cop_rd_req` waits. The request completes one cycle after a command word arrives.
- R4: While the outbound queue chosen by `cop_wr_sel` is full, `cop_wr_ack` stays 0 and a held write stores nothing. The selection encoding is 0 for the response queue and 1 for the alert queue. The write completes once the host has popped that queue.
- R5: A host read at address 1 or 2 returns the oldest word and removes it. A read of an empty response or alert queue returns the last word removed from that queue.
- R6: A host write to a full command queue replaces the newest stored word. The count and the older words are unchanged.
- R7: The status word at address 3 has three fields: bits [3:0] hold the free command slots (depth 4), bits [11:8] hold the response count (depth 1), and bits [19:16] hold the alert count (depth 1). All other bits are 0.
- R8: `host_irq` is 1 in the cycle after a coprocessor write into the alert queue completes.
- R9: `host_irq` stays 1 until either of two things happens: a host read at address 2 leaves the alert queue empty, or a host write at address 3 has bit 0 set. A write at address 3 with bit 0 clear has no effect. If a new alert write and a clear land in the same cycle, the interrupt stays set.
- R10: If a host command write and a coprocessor command read complete on the same edge, the command count is unchanged and the word order is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cop_rd_req | input | 1 | Coprocessor requests a command word |
| cop_rd_ack | output | 1 | A command word is available; the read completes on this edge |
| cop_rd_data | output | 32 | Oldest command word |
| cop_wr_req | input | 1 | Coprocessor requests an outbound write |
| cop_wr_sel | input | 1 | 0 selects the response queue, 1 selects the alert queue |
| cop_wr_data | input | 32 | Outbound word |
| cop_wr_ack | output | 1 | Selected queue has room; the write completes on this edge |
| host_sel | input | 1 | Host access strobe |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 2 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid in the cycle of the read strobe |
| host_irq | output | 1 | Interrupt request to the host |

## Verification
The hardest cases to reach are the coincidences on a single edge. A host command write has to land on the same edge as a coprocessor command read. An alert write has to arrive on the same edge as a clear of the interrupt. The bench drives both sides from one process, so it can place those two accesses on one edge. The stalled outbound write is reached by holding `cop_wr_req` against a full queue across several cycles and then popping that queue from the host. This shows the held write completing on the edge after the pop, not before.

// File: rtl/mbox_pkg.sv
// Package: shared constants and the host register address map of the mailbox unit.
// Assumes a 2-bit word address on the host port.
package mbox_pkg;
    localparam int unsigned FIELD_W = 4;  // width of each count field in the status word

    typedef enum logic [1:0] {
        HREG_CMD  = 2'd0,  // command queue push
        HREG_RESP = 2'd1,  // response queue pop
        HREG_ALRT = 2'd2,  // alert queue pop
        HREG_CTRL = 2'd3   // status read / control write
    } hreg_e;
endpackage

// File: rtl/mbox_fifo.sv
// Module: mbox_fifo
// A circular queue of DEPTH words with a level count.
// When OVERWRITE is set, a push into a full queue with no pop in the same cycle
// replaces the newest word. Without OVERWRITE, such a push is dropped, so the
// caller must gate it.
// While the queue is empty, out_data shows the last word popped.
// Assumes DEPTH >= 1.
module mbox_fifo #(
    parameter int unsigned DEPTH     = 4,
    parameter int unsigned W         = 32,
    parameter bit          OVERWRITE = 1'b0,
    parameter int unsigned CW        = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]  mem [DEPTH];
    logic [W-1:0]  last_q;
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] cnt;
    logic          do_pop, do_push, do_ovw;

    // Advance a pointer with wrap.
    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Step a pointer back with wrap.
    function automatic logic [AW-1:0] ptr_dec(input logic [AW-1:0] p);
        return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
    endfunction

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign do_ovw  = OVERWRITE && push && full && !do_pop;

    // Word storage: normal write at the tail, overwrite at the newest slot.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end else if (do_ovw) begin
            mem[ptr_dec(wr_ptr)] <= push_data;
        end
    end

    // Pointers, level count and last-popped word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
            last_q <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_inc(wr_ptr);
            if (do_pop) begin
                rd_ptr <= ptr_inc(rd_ptr);
                last_q <= mem[rd_ptr];
            end
            case ({do_push, do_pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // Head word, or the last popped word when empty.
    always_comb begin
        out_data = empty ? last_q : mem[rd_ptr];
    end

    assign count = cnt;

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH)); // R2
    AST_PUSHPOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty) |=> (cnt == $past(cnt))); // R10
    AST_OVW_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (OVERWRITE && push && !pop && full) |=> full); // R6
endmodule

// File: rtl/mbox_irq.sv
// Module: mbox_irq
// Interrupt flag toward the host. A set request wins over a clear in the same cycle.
// Assumes set and clr are single-cycle qualified events.
module mbox_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic irq
);
    logic irq_q;

    // Hold, set or clear the request flag.
    always_ff @(posedge clk) begin
        if (!rst_n)    irq_q <= 1'b0;
        else if (set)  irq_q <= 1'b1;
        else if (clr)  irq_q <= 1'b0;
    end

    assign irq = irq_q;

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> irq); // R8
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !irq); // R9
    AST_IRQ_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !set && !clr) |=> irq); // R9
endmodule

// File: rtl/mbox_host_regs.sv
// Module: mbox_host_regs
// Decodes host accesses into queue strobes and builds the read data and the status word.
// Assumes a read takes effect on the clock edge that ends the strobe cycle.
module mbox_host_regs #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CMD_DEPTH = 4,
    parameter int unsigned CMD_CW    = 3,
    parameter int unsigned RSP_CW    = 1,
    parameter int unsigned ALR_CW    = 1
) (
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [CMD_CW-1:0] cmd_cnt,
    input  logic [RSP_CW-1:0] rsp_cnt,
    input  logic [ALR_CW-1:0] alr_cnt,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [DATA_W-1:0] alr_data,
    output logic              cmd_push,
    output logic              rsp_pop,
    output logic              alr_pop,
    output logic              ctrl_clr,
    output logic [DATA_W-1:0] host_rdata
);
    import mbox_pkg::*;

    logic              wr_acc, rd_acc;
    logic [CMD_CW-1:0] cmd_free;
    logic [DATA_W-1:0] status;
    hreg_e             reg_sel;

    assign reg_sel  = hreg_e'(host_addr);
    assign wr_acc   = host_sel && host_we;
    assign rd_acc   = host_sel && !host_we;
    assign cmd_free = CMD_CW'(CMD_DEPTH) - cmd_cnt;

    // Access strobes per register.
    always_comb begin
        cmd_push = wr_acc && (reg_sel == HREG_CMD);
        rsp_pop  = rd_acc && (reg_sel == HREG_RESP);
        alr_pop  = rd_acc && (reg_sel == HREG_ALRT);
        ctrl_clr = wr_acc && (reg_sel == HREG_CTRL) && host_wdata[0];
    end

    // Pack the three count fields into the status word.
    always_comb begin
        status        = '0;
        status[3:0]   = FIELD_W'(cmd_free);
        status[11:8]  = FIELD_W'(rsp_cnt);
        status[19:16] = FIELD_W'(alr_cnt);
    end

    // Read data mux by address.
    always_comb begin
        case (reg_sel)
            HREG_RESP: host_rdata = rsp_data;
            HREG_ALRT: host_rdata = alr_data;
            HREG_CTRL: host_rdata = status;
            default:   host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_unit.sv
// Module: mbox_unit (top)
// Connects the command, response and alert queues to the coprocessor channel
// ports and the host register port, and drives the host interrupt.
// Assumes the coprocessor holds a request until it is acknowledged.
module mbox_unit #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned CMD_DEPTH = 4,
    parameter int unsigned RSP_DEPTH = 1,
    parameter int unsigned ALR_DEPTH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cop_rd_req,
    output logic              cop_rd_ack,
    output logic [DATA_W-1:0] cop_rd_data,
    input  logic              cop_wr_req,
    input  logic              cop_wr_sel,
    input  logic [DATA_W-1:0] cop_wr_data,
    output logic              cop_wr_ack,
    input  logic              host_sel,
    input  logic              host_we,
    input  logic [1:0]        host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_irq
);
    localparam int unsigned CMD_CW = $clog2(CMD_DEPTH + 1);
    localparam int unsigned RSP_CW = $clog2(RSP_DEPTH + 1);
    localparam int unsigned ALR_CW = $clog2(ALR_DEPTH + 1);

    logic              cmd_push, cmd_full, cmd_empty;
    logic              rsp_push, rsp_pop, rsp_full, rsp_empty;
    logic              alr_push, alr_pop, alr_full, alr_empty;
    logic              ctrl_clr, irq_clr;
    logic [CMD_CW-1:0] cmd_cnt;
    logic [RSP_CW-1:0] rsp_cnt;
    logic [ALR_CW-1:0] alr_cnt;
    logic [DATA_W-1:0] rsp_data, alr_data;

    // Channel handshakes: stall on empty command queue or full target queue.
    always_comb begin
        cop_rd_ack = !cmd_empty;
        cop_wr_ack = cop_wr_sel ? !alr_full : !rsp_full;
        rsp_push   = cop_wr_req && !cop_wr_sel && !rsp_full;
        alr_push   = cop_wr_req &&  cop_wr_sel && !alr_full;
        irq_clr    = ctrl_clr || (alr_pop && (alr_cnt <= ALR_CW'(1)));
    end

    mbox_fifo #(.DEPTH(CMD_DEPTH), .W(DATA_W), .OVERWRITE(1'b1), .CW(CMD_CW)) u_cmd (
        .clk(clk), .rst_n(rst_n), .push(cmd_push), .push_data(host_wdata),
        .pop(cop_rd_req), .out_data(cop_rd_data), .count(cmd_cnt),
        .full(cmd_full), .empty(cmd_empty));

    mbox_fifo #(.DEPTH(RSP_DEPTH), .W(DATA_W), .OVERWRITE(1'b0), .CW(RSP_CW)) u_rsp (
        .clk(clk), .rst_n(rst_n), .push(rsp_push), .push_data(cop_wr_data),
        .pop(rsp_pop), .out_data(rsp_data), .count(rsp_cnt),
        .full(rsp_full), .empty(rsp_empty));

    mbox_fifo #(.DEPTH(ALR_DEPTH), .W(DATA_W), .OVERWRITE(1'b0), .CW(ALR_CW)) u_alr (
        .clk(clk), .rst_n(rst_n), .push(alr_push), .push_data(cop_wr_data),
        .pop(alr_pop), .out_data(alr_data), .count(alr_cnt),
        .full(alr_full), .empty(alr_empty));

    mbox_host_regs #(.DATA_W(DATA_W), .CMD_DEPTH(CMD_DEPTH), .CMD_CW(CMD_CW),
                     .RSP_CW(RSP_CW), .ALR_CW(ALR_CW)) u_regs (
        .host_sel(host_sel), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .cmd_cnt(cmd_cnt), .rsp_cnt(rsp_cnt),
        .alr_cnt(alr_cnt), .rsp_data(rsp_data), .alr_data(alr_data),
        .cmd_push(cmd_push), .rsp_pop(rsp_pop), .alr_pop(alr_pop),
        .ctrl_clr(ctrl_clr), .host_rdata(host_rdata));

    mbox_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set(alr_push), .clr(irq_clr), .irq(host_irq));

    AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_rd_req && !cop_rd_ack && !cmd_push) |=> !cop_rd_ack); // R3
    AST_WR_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (cop_wr_req && !cop_wr_ack && !rsp_pop && !alr_pop)
        |=> ($stable(rsp_cnt) && $stable(alr_cnt))); // R4
    AST_EMPTY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_cnt == '0) |-> !cop_rd_ack); // R3
endmodule

// File: tb/mbox_unit_test.sv
// Scoreboard bench for mbox_unit. Drivers change inputs 2 ns after a rising edge;
// all sampling is done at the falling edge.
module mbox_unit_test;
    localparam int unsigned CLK_NS = 20;  // 50 MHz

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cop_rd_req = 1'b0, cop_wr_req = 1'b0, cop_wr_sel = 1'b0;
    logic        cop_rd_ack, cop_wr_ack, host_irq;
    logic [31:0] cop_rd_data, cop_wr_data = '0;
    logic        host_sel = 1'b0, host_we = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [31:0] host_wdata = '0, host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] exp_cmd[$];
    logic [31:0] rd_val;

    always #(CLK_NS / 2) clk = ~clk;

    mbox_unit uut (
        .clk(clk), .rst_n(rst_n), .cop_rd_req(cop_rd_req), .cop_rd_ack(cop_rd_ack),
        .cop_rd_data(cop_rd_data), .cop_wr_req(cop_wr_req), .cop_wr_sel(cop_wr_sel),
        .cop_wr_data(cop_wr_data), .cop_wr_ack(cop_wr_ack), .host_sel(host_sel),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .host_irq(host_irq));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] stat(input int free, input int rsp, input int alr);
        return 32'(free) | (32'(rsp) << 8) | (32'(alr) << 16);
    endfunction

    // Driver: host write; command words go to the scoreboard (newest replaced when full).
    task automatic host_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        host_sel = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
        if (a == 2'd0) begin
            if (exp_cmd.size() == 4 && !cop_rd_req) exp_cmd[3] = d;
            else exp_cmd.push_back(d);
        end
        @(posedge clk); #2;
        host_sel = 1'b0; host_we = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #2;
        host_sel = 1'b1; host_we = 1'b0; host_addr = a;
        @(negedge clk);
        d = host_rdata;
        @(posedge clk); #2;
        host_sel = 1'b0;
    endtask

    task automatic cop_write(input logic sel, input logic [31:0] d);
        @(posedge clk); #2;
        cop_wr_req = 1'b1; cop_wr_sel = sel; cop_wr_data = d;
        @(negedge clk);
        while (!cop_wr_ack) @(negedge clk);
        @(posedge clk); #2;
        cop_wr_req = 1'b0;
    endtask

    task automatic cop_drain();
        @(posedge clk); #2;
        cop_rd_req = 1'b1;
        wait (exp_cmd.size() == 0);
        @(posedge clk); #2;
        cop_rd_req = 1'b0;
    endtask

    // Monitor: every completed channel read is compared with the scoreboard head (R2).
    always @(negedge clk) begin
        if (rst_n && cop_rd_req && cop_rd_ack) begin
            if (exp_cmd.size() == 0) chk("R2 unexpected word", cop_rd_data, 32'hxxxxxxxx);
            else chk("R2 command order", cop_rd_data, exp_cmd.pop_front());
        end
    end

    initial begin
        #(CLK_NS * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        chk("R1 irq", 32'(host_irq), 0);
        chk("R1 rd_ack", 32'(cop_rd_ack), 0);
        chk("R1 wr_ack", 32'(cop_wr_ack), 1);
        host_read(2'd3, rd_val);
        chk("R1 R7 status", rd_val, 32'h0000_0004);

        // R3 read stalls while empty, then completes
        @(posedge clk); #2 cop_rd_req = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R3 stall ack", 32'(cop_rd_ack), 0);
        end
        host_write(2'd0, 32'hA000_0001);
        @(posedge clk); #2 cop_rd_req = 1'b0;
        chk("R3 delivered", 32'(exp_cmd.size()), 0);

        // R2 and R7 ordered fill of four
        for (int i = 0; i < 4; i++) host_write(2'd0, 32'hB000_0000 + 32'(i));
        host_read(2'd3, rd_val);
        chk("R7 full status", rd_val, stat(0, 0, 0));
        // R6 overwrite of the newest word
        host_write(2'd0, 32'hC0DE_0006);
        host_read(2'd3, rd_val);
        chk("R6 count kept", rd_val, stat(0, 0, 0));
        cop_drain();
        host_read(2'd3, rd_val);
        chk("R2 drained status", rd_val, stat(4, 0, 0));

        // R10 push and pop on the same edge
        host_write(2'd0, 32'hD000_0001);
        host_write(2'd0, 32'hD000_0002);
        @(posedge clk); #2;
        cop_rd_req = 1'b1;
        host_sel = 1'b1; host_we = 1'b1; host_addr = 2'd0; host_wdata = 32'hD000_0003;
        exp_cmd.push_back(32'hD000_0003);
        @(posedge clk); #2;
        cop_rd_req = 1'b0; host_sel = 1'b0; host_we = 1'b0;
        host_read(2'd3, rd_val);
        chk("R10 count unchanged", rd_val, stat(2, 0, 0));
        cop_drain();

        // R4 and R5 response queue
        cop_write(1'b0, 32'h5E5_0001);
        host_read(2'd3, rd_val);
        chk("R7 response count", rd_val, stat(4, 1, 0));
        @(posedge clk); #2;
        cop_wr_req = 1'b1; cop_wr_sel = 1'b0; cop_wr_data = 32'h5E5_0002;
        repeat (3) begin
            @(negedge clk);
            chk("R4 stall ack", 32'(cop_wr_ack), 0);
        end
        host_read(2'd3, rd_val);
        chk("R4 nothing stored", rd_val, stat(4, 1, 0));
        host_read(2'd1, rd_val);
        chk("R5 response pop", rd_val, 32'h5E5_0001);
        @(negedge clk);
        chk("R4 resumes", 32'(cop_wr_ack), 1);
        @(posedge clk); #2 cop_wr_req = 1'b0;
        host_read(2'd1, rd_val);
        chk("R4 held word stored", rd_val, 32'h5E5_0002);
        host_read(2'd1, rd_val);
        chk("R5 empty returns last", rd_val, 32'h5E5_0002);

        // R8 and R9 alert queue and interrupt
        cop_write(1'b1, 32'hA1E7_0001);
        @(negedge clk);
        chk("R8 irq raised", 32'(host_irq), 1);
        host_write(2'd3, 32'h0);
        @(negedge clk);
        chk("R9 bit0 clear ignored", 32'(host_irq), 1);
        host_write(2'd3, 32'h1);
        @(negedge clk);
        chk("R9 control clear", 32'(host_irq), 0);
        host_read(2'd3, rd_val);
        chk("R7 alert count", rd_val, stat(4, 0, 1));
        host_read(2'd2, rd_val);
        chk("R5 alert pop", rd_val, 32'hA1E7_0001);
        cop_write(1'b1, 32'hA1E7_0002);
        @(negedge clk);
        chk("R8 irq raised again", 32'(host_irq), 1);
        host_read(2'd2, rd_val);
        chk("R5 alert pop 2", rd_val, 32'hA1E7_0002);
        @(negedge clk);
        chk("R9 drain clears", 32'(host_irq), 0);
        host_read(2'd2, rd_val);
        chk("R5 alert empty last", rd_val, 32'hA1E7_0002);

        // R9 set wins over clear on the same edge
        @(posedge clk); #2;
        cop_wr_req = 1'b1; cop_wr_sel = 1'b1; cop_wr_data = 32'hA1E7_0003;
        host_sel = 1'b1; host_we = 1'b1; host_addr = 2'd3; host_wdata = 32'h1;
        @(posedge clk); #2;
        cop_wr_req = 1'b0; host_sel = 1'b0; host_we = 1'b0;
        @(negedge clk);
        chk("R9 set wins", 32'(host_irq), 1);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule